// File: doc/BRIEF.md
# Multi-Format Serial Audio Receive Port

This block is the receive side of a serial audio port that works as a bus target. Bit clock, frame sync and one serial data line arrive from outside. They are brought into the core clock domain, and the block finds the rising edge of the selected bit-clock phase. It follows the framing of the selected protocol: TDM with one frame-sync pulse, I2S, or left-justified. From that framing it gathers eight PCM channel words. Each channel reads from its own programmable slot.

Word length, a receive-only start offset, frame-sync polarity and bit-clock sampling edge are all set through static configuration inputs. Each channel word is presented left-aligned in 32 bits. All eight words change together, and a one-cycle strobe marks each update once per frame. A channel whose slot does not fit in the frame keeps its last word, and a sticky error flag records the event.

Top module: `aud_rx_port`

## Requirements
- R1: `cfgFormat` selects the framing. With 00 (TDM) a frame starts where the frame-sync level goes from 0 to 1. With 01 (I2S) a frame starts where the level goes from 1 to 0, and data begins one bit clock after that edge. With 10 (left-justified) a frame starts on a 0-to-1 transition and data begins on the same bit clock.
- R2: `cfgWordLen` codes 00/01/10/11 select 16/20/24/32-bit words. The first received bit lands in output bit 31, and the bits below the word are zero.
- R3: In TDM each channel `c` takes its 5-bit slot number from `cfgSlotMap[5c+4:5c]`. Slot `s` is the word that begins `s` times the word length bit clocks after the data start.
- R4: In I2S and left-justified modes, bit 4 of a slot number selects the half: 0 for the first half, 1 for the second. Bits 3:0 count slots from the start of that half. The second half starts at the opposite frame-sync transition, and slot counting restarts there.
- R5: `cfgRxOffset` (0 to 31) delays the data start of every frame, and of every half in I2S and left-justified modes, by that many bit clocks.
- R6: When `cfgFsyncInv` is 1, the frame-sync input is inverted before framing is decoded.
- R7: When `cfgBclkInv` is 0, data and frame sync are sampled on the rising edge of the bit-clock input. When it is 1, they are sampled on the falling edge.
- R8: When every channel word of a frame is complete, `frameValid` pulses for exactly one core cycle, and all eight fields of `chWords` (channel `c` in bits `32c+31:32c`) update in that same cycle. At any other time `chWords` does not change, and no frame pulses more than once.
- R9: If a frame ends before some channel's slot is fully received, the complete channels update, the incomplete ones keep their previous words, `frameValid` pulses at the start of the next frame, and `slotErr` goes to 1 and stays there until reset.
- R10: While `rstN` is low, `chWords`, `frameValid` and `slotErr` are cleared to 0 on the next core clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; oversamples the serial lines |
| rstN | input | 1 | Synchronous active-low reset |
| bclkIn | input | 1 | External bit clock |
| fsyncIn | input | 1 | External frame sync |
| sdataIn | input | 1 | Serial data, MSB first |
| cfgFormat | input | 2 | Framing select: 00 TDM, 01 I2S, 10 left-justified |
| cfgWordLen | input | 2 | Word length code: 16/20/24/32 bits |
| cfgRxOffset | input | 5 | Receive data start delay in bit clocks |
| cfgFsyncInv | input | 1 | Invert frame sync |
| cfgBclkInv | input | 1 | Sample on falling bit-clock edge |
| cfgSlotMap | input | 40 | Eight 5-bit slot numbers, channel 0 in the low bits |
| chWords | output | 256 | Eight left-aligned 32-bit channel words |
| frameValid | output | 1 | One-cycle update strobe |
| slotErr | output | 1 | Sticky incomplete-slot flag |

## Verification
The bench drives scattered slot maps that reach slot 31 in TDM. A design that counts slots with the wrong stride, or ignores the high slot bit, returns bits taken from the wrong place in the random serial stream. I2S and left-justified frames test the one-bit I2S delay and the slot restart at the second half. A design that gets either wrong produces words shifted by one bit or taken from the wrong half.

Other runs combine an offset with both inversion bits. If an inversion is ignored, the block locks to the wrong edges and every word comes out wrong. A final group of frames is made deliberately too short for some slots. A design that clears those channels, fails to keep the error flag set, or drops the pulse for the partial frame is caught by the scoreboard.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_TDM = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_RSV = 2'b11
  } rxFmtE;

  // Strobes and indices passed from control to datapath for one sample event
  typedef struct packed {
    logic       shiftEn;
    logic [4:0] bitIdx;
    logic [4:0] slotIdx;
    logic       halfSel;
    logic       commit;
    logic       frameStart;
  } rxStrobeT;

  function automatic logic [4:0] lastBitOf(input logic [1:0] code);
    case (code)
      2'b00:   lastBitOf = 5'd15;
      2'b01:   lastBitOf = 5'd19;
      2'b10:   lastBitOf = 5'd23;
      default: lastBitOf = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_front.sv
module aud_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bclkIn,
  input  logic fsyncIn,
  input  logic sdataIn,
  input  logic cfgFsyncInv,
  input  logic cfgBclkInv,
  output logic sampleEv,
  output logic fsLvl,
  output logic dataBit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] bSync, fSync, dSync;
  logic prevEff;
  logic effClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      fSync <= '0;
      dSync <= '0;
    end else begin
      bSync <= {bSync[TOP-1:0], bclkIn};
      fSync <= {fSync[TOP-1:0], fsyncIn};
      dSync <= {dSync[TOP-1:0], sdataIn};
    end
  end

  assign effClk = bSync[TOP] ^ cfgBclkInv;

  always_ff @(posedge clk) begin
    if (!rstN) prevEff <= 1'b1;
    else       prevEff <= effClk;
  end

  assign sampleEv = effClk & ~prevEff;
  assign fsLvl    = fSync[TOP] ^ cfgFsyncInv;
  assign dataBit  = dSync[TOP];

endmodule

// File: rtl/aud_rx_ctrl.sv
module aud_rx_ctrl
  import aud_rx_pkg::*;
#(
  parameter int OFS_W = 5,
  parameter int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEv,
  input  logic             fsLvl,
  input  logic [1:0]       cfgFormat,
  input  logic [1:0]       cfgWordLen,
  input  logic [OFS_W-1:0] cfgRxOffset,
  input  logic             doneAll,
  output rxStrobeT         strobe
);
  logic             primed, prevFs, inFrame, committed, halfReg;
  logic [CNT_W-1:0] skipCnt, slotCnt;
  logic [4:0]       bitCnt;

  logic             isHalf, fsRise, fsFall, frameEdge, halfEdge, segStart;
  logic             frameOk, inSlots, curHalf, emit;
  logic [CNT_W-1:0] lead, curSkip, curSlot, slotLimit;
  logic [4:0]       curBit, lastBit;

  always_comb begin
    isHalf    = (cfgFormat == FMT_I2S) || (cfgFormat == FMT_LJ);
    fsRise    = primed & fsLvl & ~prevFs;
    fsFall    = primed & ~fsLvl & prevFs;
    frameEdge = (cfgFormat == FMT_I2S) ? fsFall : fsRise;
    if (cfgFormat == FMT_I2S)     halfEdge = fsRise;
    else if (cfgFormat == FMT_LJ) halfEdge = fsFall;
    else                          halfEdge = 1'b0;
    segStart  = frameEdge | halfEdge;
    lead      = {1'b0, cfgRxOffset} + {{(CNT_W-1){1'b0}}, (cfgFormat == FMT_I2S)};
    curSkip   = segStart ? lead : skipCnt;
    curBit    = segStart ? 5'd0 : bitCnt;
    curSlot   = segStart ? '0 : slotCnt;
    curHalf   = segStart ? halfEdge : halfReg;
    slotLimit = isHalf ? CNT_W'(16) : CNT_W'(32);
    inSlots   = curSlot < slotLimit;
    frameOk   = inFrame | frameEdge;
    emit      = sampleEv & frameOk & (curSkip == '0) & inSlots;
    lastBit   = lastBitOf(cfgWordLen);

    strobe.shiftEn    = emit;
    strobe.bitIdx     = curBit;
    strobe.slotIdx    = curSlot[4:0];
    strobe.halfSel    = curHalf;
    strobe.frameStart = sampleEv & frameEdge;
    strobe.commit     = (doneAll & inFrame & ~committed) |
                        (sampleEv & frameEdge & inFrame & ~committed);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed    <= 1'b0;
      prevFs    <= 1'b0;
      inFrame   <= 1'b0;
      committed <= 1'b0;
      halfReg   <= 1'b0;
      skipCnt   <= '0;
      slotCnt   <= '0;
      bitCnt    <= '0;
    end else begin
      if (strobe.commit) committed <= 1'b1;
      if (sampleEv) begin
        primed  <= 1'b1;
        prevFs  <= fsLvl;
        halfReg <= curHalf;
        if (frameEdge) begin
          inFrame   <= 1'b1;
          committed <= 1'b0;
        end
        if (curSkip != '0) begin
          skipCnt <= curSkip - 1'b1;
          bitCnt  <= curBit;
          slotCnt <= curSlot;
        end else begin
          skipCnt <= '0;
          if (inSlots && curBit == lastBit) begin
            bitCnt  <= 5'd0;
            slotCnt <= curSlot + 1'b1;
          end else if (inSlots) begin
            bitCnt  <= curBit + 1'b1;
            slotCnt <= curSlot;
          end else begin
            bitCnt  <= curBit;
            slotCnt <= curSlot;
          end
        end
      end
    end
  end

endmodule

// File: rtl/aud_rx_data.sv
module aud_rx_data
  import aud_rx_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SLOT_W   = 5,
  parameter int WORD_MAX = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dataBit,
  input  logic [1:0]                 cfgFormat,
  input  logic [1:0]                 cfgWordLen,
  input  logic [NUM_CH*SLOT_W-1:0]   cfgSlotMap,
  input  rxStrobeT                   strobe,
  output logic                       doneAll,
  output logic [NUM_CH*WORD_MAX-1:0] chWords,
  output logic                       frameValid,
  output logic                       slotErr
);
  localparam logic [4:0] MSB_IDX = 5'(WORD_MAX - 1);

  logic [NUM_CH-1:0]               done;
  logic [NUM_CH-1:0][WORD_MAX-1:0] acc;
  logic [NUM_CH-1:0][WORD_MAX-1:0] wordReg;
  logic                            isHalf;
  logic [4:0]                      lastBit;

  assign isHalf  = (cfgFormat == FMT_I2S) || (cfgFormat == FMT_LJ);
  assign lastBit = lastBitOf(cfgWordLen);
  assign doneAll = &done;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SLOT_W-1:0] slotCfg;
    logic              hit;

    assign slotCfg = cfgSlotMap[c*SLOT_W +: SLOT_W];
    assign hit = isHalf ? ((slotCfg[4] == strobe.halfSel) &&
                           (slotCfg[3:0] == strobe.slotIdx[3:0]))
                        : (slotCfg == strobe.slotIdx);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc[c]     <= '0;
        done[c]    <= 1'b0;
        wordReg[c] <= '0;
      end else begin
        if (strobe.commit && done[c]) wordReg[c] <= acc[c];
        if (strobe.frameStart) done[c] <= 1'b0;
        if (strobe.shiftEn && hit) begin
          if (strobe.bitIdx == 5'd0) acc[c] <= {dataBit, {(WORD_MAX-1){1'b0}}};
          else                       acc[c][MSB_IDX - strobe.bitIdx] <= dataBit;
          if (strobe.bitIdx == lastBit) done[c] <= 1'b1;
        end
      end
    end

    assign chWords[c*WORD_MAX +: WORD_MAX] = wordReg[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      slotErr    <= 1'b0;
    end else begin
      frameValid <= strobe.commit;
      if (strobe.commit && !doneAll) slotErr <= 1'b1;
    end
  end

endmodule

// File: rtl/aud_rx_port.sv
module aud_rx_port
  import aud_rx_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SLOT_W      = 5,
  parameter int WORD_MAX    = 32,
  parameter int OFS_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bclkIn,
  input  logic                       fsyncIn,
  input  logic                       sdataIn,
  input  logic [1:0]                 cfgFormat,
  input  logic [1:0]                 cfgWordLen,
  input  logic [OFS_W-1:0]           cfgRxOffset,
  input  logic                       cfgFsyncInv,
  input  logic                       cfgBclkInv,
  input  logic [NUM_CH*SLOT_W-1:0]   cfgSlotMap,
  output logic [NUM_CH*WORD_MAX-1:0] chWords,
  output logic                       frameValid,
  output logic                       slotErr
);
  logic     sampleEv, fsLvl, dataBit, doneAll;
  rxStrobeT strobe;

  aud_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsyncIn(fsyncIn),
    .sdataIn(sdataIn), .cfgFsyncInv(cfgFsyncInv), .cfgBclkInv(cfgBclkInv),
    .sampleEv(sampleEv), .fsLvl(fsLvl), .dataBit(dataBit)
  );

  aud_rx_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEv(sampleEv), .fsLvl(fsLvl),
    .cfgFormat(cfgFormat), .cfgWordLen(cfgWordLen), .cfgRxOffset(cfgRxOffset),
    .doneAll(doneAll), .strobe(strobe)
  );

  aud_rx_data #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .WORD_MAX(WORD_MAX)) u_data (
    .clk(clk), .rstN(rstN), .dataBit(dataBit), .cfgFormat(cfgFormat),
    .cfgWordLen(cfgWordLen), .cfgSlotMap(cfgSlotMap), .strobe(strobe),
    .doneAll(doneAll), .chWords(chWords), .frameValid(frameValid),
    .slotErr(slotErr)
  );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int OUT_W = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic [OUT_W-1:0] chWords,
  input logic             frameValid,
  input logic             slotErr
);
  // R10
  rst_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!frameValid && !slotErr && chWords == '0));

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R8
  words_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> $stable(chWords));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotErr |=> slotErr);

  // R9
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotErr) |-> frameValid);

endmodule

bind aud_rx_port aud_rx_chk #(.OUT_W(NUM_CH*WORD_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .chWords(chWords),
  .frameValid(frameValid), .slotErr(slotErr)
);

// File: tb/sim_aud_rx_port.sv
`timescale 1ns/1ps
module sim_aud_rx_port;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bclkIn = 1'b0, fsyncIn = 1'b0, sdataIn = 1'b0;
  logic [1:0]   cfgFormat = 2'b00, cfgWordLen = 2'b11;
  logic [4:0]   cfgRxOffset = '0;
  logic         cfgFsyncInv = 1'b0, cfgBclkInv = 1'b0;
  logic [39:0]  cfgSlotMap = '0;
  logic [255:0] chWords;
  logic         frameValid, slotErr;

  typedef struct packed {
    logic [255:0] w;
    logic         e;
  } expT;

  expT          expQ[$];
  logic [255:0] expW;
  logic         expErr;
  int           checks = 0, failures = 0;
  string        gTag = "R10";
  bit           finished = 1'b0;

  always #2.5 clk = ~clk;

  aud_rx_port u0 (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsyncIn(fsyncIn), .sdataIn(sdataIn),
    .cfgFormat(cfgFormat), .cfgWordLen(cfgWordLen), .cfgRxOffset(cfgRxOffset),
    .cfgFsyncInv(cfgFsyncInv), .cfgBclkInv(cfgBclkInv), .cfgSlotMap(cfgSlotMap),
    .chWords(chWords), .frameValid(frameValid), .slotErr(slotErr)
  );

  // Monitor: pops one expected item per update strobe (R8, R9)
  always @(negedge clk) begin
    if (rstN && frameValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL %s R8 unexpected strobe: actual=1 expected=0", gTag);
      end else begin
        expT it;
        it = expQ.pop_front();
        if (chWords !== it.w) begin
          failures++;
          $display("FAIL %s words: actual=%h expected=%h", gTag, chWords, it.w);
        end
        checks++;
        if (slotErr !== it.e) begin
          failures++;
          $display("FAIL %s R9 error flag: actual=%b expected=%b", gTag, slotErr, it.e);
        end
      end
    end
  end

  function automatic int wordLen(input logic [1:0] code);
    case (code)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic sendBit(input logic fsv, input logic dv);
    @(negedge clk);
    bclkIn  = cfgBclkInv;
    fsyncIn = fsv ^ cfgFsyncInv;
    sdataIn = dv;
    repeat (4) @(negedge clk);
    bclkIn = ~cfgBclkInv;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic fsAt(input int p, input int segLen);
    case (cfgFormat)
      2'b01:   return (p >= segLen);
      2'b10:   return (p < segLen);
      default: return (p == 0);
    endcase
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    bclkIn = cfgBclkInv;
    repeat (4) @(negedge clk);
    checks++;
    if (frameValid !== 1'b0 || slotErr !== 1'b0 || chWords !== '0) begin
      failures++;
      $display("FAIL R10 reset state: actual=%b/%b/%h expected=0/0/0",
               frameValid, slotErr, chWords);
    end
    expQ.delete();
    expW = '0;
    expErr = 1'b0;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic leadIn();
    for (int i = 0; i < 4; i++) sendBit(cfgFormat == 2'b01, 1'b0);
  endtask

  task automatic runFrame(input int segLen);
    logic stream [0:1023];
    int   w, lead, len, base, segEnd, s;
    bit   half;
    logic [31:0] word;
    expT  it;
    w    = wordLen(cfgWordLen);
    half = (cfgFormat == 2'b01) || (cfgFormat == 2'b10);
    len  = half ? 2 * segLen : segLen;
    lead = int'(cfgRxOffset) + ((cfgFormat == 2'b01) ? 1 : 0);
    for (int p = 0; p < len; p++) stream[p] = 1'($urandom_range(0, 1));
    for (int c = 0; c < 8; c++) begin
      s = int'(cfgSlotMap[c*5 +: 5]);
      if (half) begin
        base   = ((s >= 16) ? segLen : 0) + lead + (s % 16) * w;
        segEnd = (s >= 16) ? len : segLen;
      end else begin
        base   = lead + s * w;
        segEnd = len;
      end
      if (base + w <= segEnd) begin
        word = '0;
        for (int k = 0; k < w; k++) word[31-k] = stream[base+k];
        expW[c*32 +: 32] = word;
      end else begin
        expErr = 1'b1;
      end
    end
    it.w = expW;
    it.e = expErr;
    expQ.push_back(it);
    for (int p = 0; p < len; p++) sendBit(fsAt(p, segLen), stream[p]);
  endtask

  task automatic finishScenario(input int segLen);
    sendBit(fsAt(0, segLen), 1'b0);
    sendBit(fsAt(1, segLen), 1'b0);
    repeat (40) @(negedge clk);
    // R8: exactly one strobe was produced for every frame
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s R8 missing strobes: actual=%0d pending expected=0", gTag, expQ.size());
    end
  endtask

  task automatic scenario(input string tag, input logic [1:0] fmt, input logic [1:0] wl,
                          input logic [4:0] ofs, input logic fInv, input logic bInv,
                          input logic [39:0] slots, input int segLen, input int frames);
    gTag        = tag;
    cfgFormat   = fmt;
    cfgWordLen  = wl;
    cfgRxOffset = ofs;
    cfgFsyncInv = fInv;
    cfgBclkInv  = bInv;
    cfgSlotMap  = slots;
    doReset();
    leadIn();
    for (int f = 0; f < frames; f++) runFrame(segLen);
    finishScenario(segLen);
  endtask

  initial begin
    expW = '0;
    expErr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 R2 R3: TDM, 32-bit words, slots 0..7 in order
    scenario("R1_R2_R3 tdm32", 2'b00, 2'b11, 5'd0, 1'b0, 1'b0,
             {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 256, 3);
    // R2 R3 R5: TDM, 16-bit words, offset 3, scattered slots up to 31
    scenario("R2_R3_R5 tdm16", 2'b00, 2'b00, 5'd3, 1'b0, 1'b0,
             {5'd12, 5'd30, 5'd9, 5'd2, 5'd17, 5'd0, 5'd5, 5'd31}, 520, 2);
    // R1 R4: I2S, 24-bit words, one-bit delay, both halves
    scenario("R1_R4 i2s24", 2'b01, 2'b10, 5'd0, 1'b0, 1'b0,
             {5'd19, 5'd3, 5'd18, 5'd2, 5'd17, 5'd1, 5'd16, 5'd0}, 100, 2);
    // R1 R4 R5 R6 R7: left-justified, 20-bit, offset 5, both inversions
    scenario("R1_R4_R5_R6_R7 lj20", 2'b10, 2'b01, 5'd5, 1'b1, 1'b1,
             {5'd19, 5'd3, 5'd17, 5'd1, 5'd4, 5'd20, 5'd0, 5'd16}, 110, 2);
    // R6 R7: TDM with inverted frame sync only, then bit clock only
    scenario("R6 tdm fsinv", 2'b00, 2'b10, 5'd1, 1'b1, 1'b0,
             {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7}, 200, 1);
    scenario("R7 tdm bclkinv", 2'b00, 2'b10, 5'd2, 1'b0, 1'b1,
             {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 200, 1);
    // R5 R9: offset 31 pushes slot 10 past the frame end
    scenario("R5_R9 tdm short", 2'b00, 2'b10, 5'd31, 1'b0, 1'b0,
             {5'd10, 5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}, 290, 3);
    // R4 R9: I2S left slot 2 overruns a 40-bit half
    scenario("R4_R9 i2s short", 2'b01, 2'b00, 5'd0, 1'b0, 1'b0,
             {5'd2, 5'd17, 5'd16, 5'd1, 5'd0, 5'd16, 5'd17, 5'd0}, 40, 2);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule